// File: doc/BRIEF.md
# FIFO Read-Side Retransmit Controller

This block sits on the read port of a FIFO with a registered output. It owns the read pointer and the output data register. On request it rewinds the read pointer to memory location zero, so that data already read can be read again from the start. It also recomputes the empty indication from the write pointer and the rewound read pointer. The memory array and the write side are outside the block. The memory is read combinationally at the address the block presents, and the write side supplies its pointer already in the read clock domain.

A retransmit is requested by driving `rt_n_i` low at a rising clock edge. A mode pin is sampled while reset is held, and it chooses when the first replayed word reaches the output register:

- **Zero-latency:** the word at location zero is loaded on the same edge that takes the request, and the pointer moves past it.
- **Normal:** the output register holds its value on that edge, and location zero is delivered by the next read.

Reads are plain level-controlled: `ren_i` high at an edge consumes one word. While `empty_o` is high a read is refused, which acts as back-pressure on the reader. The replay range is valid while no more than one memory depth of words has been written since reset.

Top module: `rd_retransmit_ctrl`

## Requirements
- R1: Reset is synchronous and active low. On the first edge after release, `dout_o` is 0 and `rd_ptr_o` is 0, so `empty_o` is 1 exactly when `wr_ptr_i` is 0.
- R2: `lat_mode_i` is sampled only on edges where `rst_n` is low: 0 selects zero-latency and 1 selects normal latency. Changing it after reset has no effect.
- R3: `rt_n_i` low at a rising edge performs a retransmit. In normal mode `rd_ptr_o` becomes 0 on that edge.
- R4: In zero-latency mode, with `wr_ptr_i` nonzero, a retransmit edge loads the word at location 0 into `dout_o` and sets `rd_ptr_o` to 1.
- R5: In normal mode, `dout_o` keeps its prior value on the retransmit edge, and the next accepted read returns the word at location 0.
- R6: `ren_i` is ignored on a retransmit edge: the pointer takes only the retransmit value.
- R7: `ren_i` high with `empty_o` low and no retransmit loads the word at address `rd_ptr_o` into `dout_o` and increments `rd_ptr_o` by one.
- R8: `ren_i` high while `empty_o` is high changes neither `dout_o` nor `rd_ptr_o`.
- R9: `empty_o` is high exactly when `wr_ptr_i` equals `rd_ptr_o`, including the cycle after a rewind.
- R10: A retransmit while `wr_ptr_i` is 0 leaves `rd_ptr_o` at 0, `empty_o` high and `dout_o` unchanged, in both modes.
- R11: `rd_addr_o` is 0 while `rt_n_i` is low. Otherwise it is the low address bits of `rd_ptr_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| lat_mode_i | input | 1 | Retransmit latency select, sampled during reset (0 zero-latency, 1 normal) |
| rt_n_i | input | 1 | Active-low retransmit request |
| ren_i | input | 1 | Read enable |
| wr_ptr_i | input | AW+1 | Write pointer from the write side, with wrap bit |
| mem_rdata_i | input | DW | Memory word at `rd_addr_o` |
| rd_addr_o | output | AW | Memory read address |
| rd_ptr_o | output | AW+1 | Read pointer, with wrap bit |
| dout_o | output | DW | Output data register |
| empty_o | output | 1 | No unread word is present |

## Verification
A retransmit and a read can fall on the same clock edge. The bench provokes this by holding `ren_i` high on every retransmit edge, across every fill level and every number of prior reads, in both latency modes. Each case is judged by the pointer value and output word just after the edge, followed by a full replay of the remaining words to their computed values. The latency mode pin is inverted after every reset, so that any leak of the pin past reset would show in the replay.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
  typedef enum logic {
    RT_ZERO_LAT   = 1'b0,
    RT_NORMAL_LAT = 1'b1
  } rt_lat_e;

  typedef struct packed {
    logic do_rt;    // rewind this edge
    logic do_rd;    // ordinary read this edge
    logic load_out; // output register captures memory word
  } rd_action_t;
endpackage

// File: rtl/rtx_mode_latch.sv
module rtx_mode_latch
  import rtx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    lat_mode_i,
  output rt_lat_e mode_o
);
  rt_lat_e mode_q;

  // The mode pin is captured only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= rt_lat_e'(lat_mode_i);
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/rtx_decide.sv
module rtx_decide
  import rtx_pkg::*;
(
  input  logic       rt_n_i,
  input  logic       ren_i,
  input  logic       empty_i,
  input  logic       wr_nonzero_i,
  input  rt_lat_e    mode_i,
  output rd_action_t act_o
);
  always_comb begin
    act_o = '0;
    if (!rt_n_i) begin
      // Retransmit wins over any read on the same edge.
      act_o.do_rt    = 1'b1;
      act_o.load_out = (mode_i == RT_ZERO_LAT) && wr_nonzero_i;
    end else if (ren_i && !empty_i) begin
      act_o.do_rd    = 1'b1;
      act_o.load_out = 1'b1;
    end
  end
endmodule

// File: rtl/rtx_rd_ptr.sv
module rtx_rd_ptr
  import rtx_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  rd_action_t act_i,
  input  logic [AW:0] wr_ptr_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW:0]   rd_ptr_o,
  output logic          empty_o
);
  localparam logic [AW:0] PTR_ZERO = '0;
  localparam logic [AW:0] PTR_ONE  = {{AW{1'b0}}, 1'b1};

  logic [AW:0] ptr_q;
  logic [AW:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (act_i.do_rt) begin
      // A word consumed on the rewind edge moves the pointer past location 0.
      ptr_d = act_i.load_out ? PTR_ONE : PTR_ZERO;
    end else if (act_i.do_rd) begin
      ptr_d = ptr_q + PTR_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= PTR_ZERO;
    else        ptr_q <= ptr_d;
  end

  // The memory is addressed at location 0 while a rewind is requested.
  assign rd_addr_o = act_i.do_rt ? '0 : ptr_q[AW-1:0];
  assign rd_ptr_o  = ptr_q;
  assign empty_o   = (wr_ptr_i == ptr_q);
endmodule

// File: rtl/rtx_out_reg.sv
module rtx_out_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] dout_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      dout_o <= '0;
    else if (load_i) dout_o <= data_i;
  end
endmodule

// File: rtl/rd_retransmit_ctrl.sv
module rd_retransmit_ctrl
  import rtx_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat_mode_i,
  input  logic          rt_n_i,
  input  logic          ren_i,
  input  logic [AW:0]   wr_ptr_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW:0]   rd_ptr_o,
  output logic [DW-1:0] dout_o,
  output logic          empty_o
);
  rt_lat_e    mode_q;
  rd_action_t act;
  logic       wr_nonzero;

  assign wr_nonzero = |wr_ptr_i;

  rtx_mode_latch u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .lat_mode_i (lat_mode_i),
    .mode_o     (mode_q)
  );

  rtx_decide u_decide (
    .rt_n_i       (rt_n_i),
    .ren_i        (ren_i),
    .empty_i      (empty_o),
    .wr_nonzero_i (wr_nonzero),
    .mode_i       (mode_q),
    .act_o        (act)
  );

  rtx_rd_ptr #(.AW(AW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_i     (act),
    .wr_ptr_i  (wr_ptr_i),
    .rd_addr_o (rd_addr_o),
    .rd_ptr_o  (rd_ptr_o),
    .empty_o   (empty_o)
  );

  rtx_out_reg #(.DW(DW)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (act.load_out),
    .data_i (mem_rdata_i),
    .dout_o (dout_o)
  );
endmodule

// File: rtl/rtx_checker.sv
module rtx_checker
  import rtx_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rt_n_i,
  input logic          ren_i,
  input logic [AW:0]   wr_ptr_i,
  input logic [DW-1:0] mem_rdata_i,
  input logic [AW:0]   rd_ptr_o,
  input logic [DW-1:0] dout_o,
  input logic          empty_o,
  input rt_lat_e       mode
);
  // R3
  rewind_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_n_i && mode == RT_NORMAL_LAT) |=> (rd_ptr_o == '0));

  // R4
  zero_lat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_n_i && mode == RT_ZERO_LAT && wr_ptr_i != '0)
      |=> (dout_o == $past(mem_rdata_i) && rd_ptr_o == {{AW{1'b0}}, 1'b1}));

  // R5
  normal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_n_i && mode == RT_NORMAL_LAT) |=> $stable(dout_o));

  // R7
  read_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_n_i && ren_i && !empty_o)
      |=> (rd_ptr_o == $past(rd_ptr_o) + 1'b1 && dout_o == $past(mem_rdata_i)));

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_n_i && empty_o) |=> ($stable(rd_ptr_o) && $stable(dout_o)));

  // R10
  rewind_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_n_i && wr_ptr_i == '0 && $stable(wr_ptr_i))
      |=> (rd_ptr_o == '0 && $stable(dout_o)));
endmodule

bind rd_retransmit_ctrl rtx_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rt_n_i      (rt_n_i),
  .ren_i       (ren_i),
  .wr_ptr_i    (wr_ptr_i),
  .mem_rdata_i (mem_rdata_i),
  .rd_ptr_o    (rd_ptr_o),
  .dout_o      (dout_o),
  .empty_o     (empty_o),
  .mode        (mode_q)
);

// File: tb/rd_retransmit_ctrl_tb_top.sv
`timescale 1ns/1ps
module rd_retransmit_ctrl_tb_top;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lat_mode_i = 1'b0;
  logic          rt_n_i = 1'b1;
  logic          ren_i = 1'b0;
  logic [AW:0]   wr_ptr_i = '0;
  logic [DW-1:0] mem_rdata_i;
  logic [AW-1:0] rd_addr_o;
  logic [AW:0]   rd_ptr_o;
  logic [DW-1:0] dout_o;
  logic          empty_o;

  logic [DW-1:0] mem [DEPTH];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign mem_rdata_i = mem[rd_addr_o];

  rd_retransmit_ctrl #(.AW(AW), .DW(DW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .lat_mode_i  (lat_mode_i),
    .rt_n_i      (rt_n_i),
    .ren_i       (ren_i),
    .wr_ptr_i    (wr_ptr_i),
    .mem_rdata_i (mem_rdata_i),
    .rd_addr_o   (rd_addr_o),
    .rd_ptr_o    (rd_ptr_o),
    .dout_o      (dout_o),
    .empty_o     (empty_o)
  );

  function automatic logic [DW-1:0] word_at(int i);
    return DW'(8'h5A + i * 13);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edge_wait();
    @(posedge clk);
    #1;
  endtask

  // One scenario: mode m, n words written, k reads before the rewind.
  task automatic run(bit m, int n, int k);
    int idx;
    int exp_dout;
    lat_mode_i = m;
    rt_n_i = 1'b1;
    ren_i = 1'b0;
    wr_ptr_i = (AW+1)'(n);
    rst_n = 1'b0;
    edge_wait();
    edge_wait();
    rst_n = 1'b1;
    lat_mode_i = ~m; // R2: pin changes after reset must not matter
    edge_wait();
    chk("R1 dout", int'(dout_o), 0);
    chk("R1 ptr", int'(rd_ptr_o), 0);
    chk("R9 empty after reset", int'(empty_o), int'(n == 0));
    exp_dout = 0;
    idx = 0;
    for (int j = 0; j < k; j++) begin
      ren_i = 1'b1;
      edge_wait();
      exp_dout = int'(word_at(idx));
      idx++;
      chk("R7 dout", int'(dout_o), exp_dout);
      chk("R7 ptr", int'(rd_ptr_o), idx);
      chk("R9 empty", int'(empty_o), int'(idx == n));
    end
    // Retransmit with read enable also high (R6).
    rt_n_i = 1'b0;
    ren_i = 1'b1;
    #1;
    chk("R11 addr during rewind", int'(rd_addr_o), 0);
    edge_wait();
    rt_n_i = 1'b1;
    ren_i = 1'b0;
    if (m == 1'b0 && n > 0) begin
      exp_dout = int'(word_at(0));
      idx = 1;
      chk("R4 dout", int'(dout_o), exp_dout);
      chk("R4 R6 ptr", int'(rd_ptr_o), 1);
    end else begin
      idx = 0;
      if (n == 0) begin
        chk("R10 dout", int'(dout_o), exp_dout);
        chk("R10 ptr", int'(rd_ptr_o), 0);
      end else begin
        chk("R5 dout held", int'(dout_o), exp_dout);
        chk("R3 R6 ptr", int'(rd_ptr_o), 0);
      end
    end
    chk("R9 empty after rewind", int'(empty_o), int'(idx == n));
    // Replay the rest; R2 is judged by the mode-dependent start point.
    while (idx < n) begin
      ren_i = 1'b1;
      #1;
      chk("R11 addr", int'(rd_addr_o), idx);
      edge_wait();
      exp_dout = int'(word_at(idx));
      idx++;
      chk("R5 R2 replay dout", int'(dout_o), exp_dout);
      chk("R7 replay ptr", int'(rd_ptr_o), idx);
    end
    chk("R9 empty at end", int'(empty_o), 1);
    ren_i = 1'b1;
    edge_wait();
    ren_i = 1'b0;
    chk("R8 dout held", int'(dout_o), exp_dout);
    chk("R8 ptr held", int'(rd_ptr_o), n);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = word_at(i);
    for (int m = 0; m < 2; m++)
      for (int n = 0; n <= DEPTH; n++)
        for (int k = 0; k <= n; k++)
          run(m[0], n, k);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule